// File: doc/BRIEF.md
# Sensor-Priority Two-Road Traffic Signal Controller

This block drives the signals at a crossing of a main road and a side road. The main road has right of way by default and keeps green for as long as no vehicle waits on the side road. A side-road vehicle triggers a handover. If both roads carry traffic, the controller alternates fixed green intervals: 45 seconds for the main road and 25 seconds for the side road. A 5-second yellow separates each green from the following red.

Time advances only on cycles where a one-second tick enable is high, so the block runs on the system clock. Each road has a three-lamp output and a two-digit packed BCD countdown. The road holding green or yellow shows the seconds left in its phase. The road held at red shows the seconds until it turns green. Seven-segment decoding and sensor conditioning belong to neighbouring blocks.

Top module: `tlc_crossing_ctrl`

## Requirements
- R1: Synchronous reset puts the block in main green with its timer cleared: main lamps 3'b001, side lamps 3'b100, main countdown 8'h45, side countdown 8'h50.
- R2: Each lamp output is encoded {red, yellow, green}. Exactly one bit of each road's lamp output is set at all times, and whenever one road shows green or yellow the other shows red.
- R3: In main green with the side sensor inactive, the phase stays main green and the timer stays cleared (countdowns 45/50), whatever the main sensor does.
- R4: In main green with both sensors active, main green lasts 45 ticks. On the 45th tick the block enters main yellow (main lamps 3'b010).
- R5: In main green with the side sensor active and the main sensor inactive, the next tick moves the block into main yellow.
- R6: Each yellow phase lasts exactly 5 ticks, whatever the sensors do. Main yellow is followed by side green, and side yellow is followed by main green.
- R7: In side green with both sensors active, side green lasts 25 ticks and then gives way to side yellow.
- R8: In side green, a tick with the side sensor inactive moves the block into side yellow.
- R9: In side green with the side sensor active and the main sensor inactive, side green holds with its timer cleared (countdowns: side 25, main 30).
- R10: The countdown of the road in green or yellow equals the phase length minus the ticks already spent in that phase. During the other road's green, the red road's countdown adds the 5-second yellow. During a yellow, both roads show the yellow's remaining time. Values are packed BCD: tens digit in bits 7:4, units digit in bits 3:0.
- R11: On cycles with the tick low, neither the phase, the timer nor any output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sec_tick | input | 1 | One-second enable, high for one clock |
| car_main | input | 1 | Vehicle present on the main road (already synchronised) |
| car_side | input | 1 | Vehicle present on the side road (already synchronised) |
| main_lamp | output | 3 | Main road lamps {red, yellow, green} |
| side_lamp | output | 3 | Side road lamps {red, yellow, green} |
| main_count | output | 8 | Main road countdown, packed BCD |
| side_count | output | 8 | Side road countdown, packed BCD |

## Verification
The phase and the elapsed-tick timer are registered, and they update on the clock edge where the tick is high. The lamps and both countdowns are decoded combinationally from those registers, so every result is due in the same clock cycle as the ticking edge. The bench drives a tick high for one clock and lowers it at the next falling edge. It samples all outputs on that falling edge, half a period after the edge that consumed the tick. Several ticks are applied before a single check, so each expected value is the state after exactly that many ticks.

// File: rtl/tlc_pkg.sv
package tlc_pkg;

  typedef enum logic [1:0] {
    PH_MAIN_GO    = 2'd0,
    PH_MAIN_AMBER = 2'd1,
    PH_SIDE_GO    = 2'd2,
    PH_SIDE_AMBER = 2'd3
  } phase_t;

  // lamp vector layout {red, yellow, green}
  localparam logic [2:0] LAMP_RED   = 3'b100;
  localparam logic [2:0] LAMP_AMBER = 3'b010;
  localparam logic [2:0] LAMP_GREEN = 3'b001;

  // two-digit packed BCD of a value below 100
  function automatic logic [7:0] to_bcd2(input int unsigned value);
    int unsigned tens;
    int unsigned units;
    tens  = (value / 10) % 10;
    units = value % 10;
    return {4'(tens), 4'(units)};
  endfunction

  // seconds left in a phase of length len after spent ticks
  function automatic int unsigned time_left(input int unsigned len,
                                            input int unsigned spent);
    return (spent >= len) ? 0 : len - spent;
  endfunction

endpackage

// File: rtl/tlc_phase_seq.sv
module tlc_phase_seq
  import tlc_pkg::*;
#(
  parameter int unsigned MAIN_T  = 45,
  parameter int unsigned SIDE_T  = 25,
  parameter int unsigned AMBER_T = 5,
  parameter int unsigned CW      = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          car_main,
  input  logic          car_side,
  output phase_t        phase,
  output logic [CW-1:0] elapsed,
  output logic          handover
);

  localparam logic [CW-1:0] MAIN_LAST  = CW'(MAIN_T - 1);
  localparam logic [CW-1:0] SIDE_LAST  = CW'(SIDE_T - 1);
  localparam logic [CW-1:0] AMBER_LAST = CW'(AMBER_T - 1);

  phase_t        phase_nxt;
  logic [CW-1:0] elapsed_nxt;
  logic          both_busy;

  assign both_busy = car_main && car_side;

  always_comb begin
    phase_nxt   = phase;
    elapsed_nxt = elapsed + 1'b1;
    unique case (phase)
      PH_MAIN_GO: begin
        if (both_busy) begin
          if (elapsed == MAIN_LAST) begin
            phase_nxt   = PH_MAIN_AMBER;
            elapsed_nxt = '0;
          end
        end else if (car_side) begin
          phase_nxt   = PH_MAIN_AMBER;
          elapsed_nxt = '0;
        end else begin
          elapsed_nxt = '0;
        end
      end
      PH_MAIN_AMBER: begin
        if (elapsed == AMBER_LAST) begin
          phase_nxt   = PH_SIDE_GO;
          elapsed_nxt = '0;
        end
      end
      PH_SIDE_GO: begin
        if (both_busy) begin
          if (elapsed == SIDE_LAST) begin
            phase_nxt   = PH_SIDE_AMBER;
            elapsed_nxt = '0;
          end
        end else if (!car_side) begin
          phase_nxt   = PH_SIDE_AMBER;
          elapsed_nxt = '0;
        end else begin
          elapsed_nxt = '0;
        end
      end
      default: begin
        if (elapsed == AMBER_LAST) begin
          phase_nxt   = PH_MAIN_GO;
          elapsed_nxt = '0;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_MAIN_GO;
      elapsed <= '0;
    end else if (tick) begin
      phase   <= phase_nxt;
      elapsed <= elapsed_nxt;
    end
  end

  assign handover = tick && (phase_nxt != phase);

  // R11: no tick, no movement
  a_r11_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(phase) && $stable(elapsed)));

  // R3: idle side road keeps main green with a cleared timer
  a_r3_idle_main_hold: assert property (@(posedge clk) disable iff (rst)
    (tick && phase == PH_MAIN_GO && !car_side) |=>
      (phase == PH_MAIN_GO && elapsed == '0));

  // R5: lone side vehicle cuts main green short
  a_r5_side_only_cut: assert property (@(posedge clk) disable iff (rst)
    (tick && phase == PH_MAIN_GO && car_side && !car_main) |=>
      (phase == PH_MAIN_AMBER));

  // R8: side road empties during its green
  a_r8_side_gone: assert property (@(posedge clk) disable iff (rst)
    (tick && phase == PH_SIDE_GO && !car_side) |=> (phase == PH_SIDE_AMBER));

  // R6: yellow order
  a_r6_amber_to_side: assert property (@(posedge clk) disable iff (rst)
    (handover && phase == PH_MAIN_AMBER) |=> (phase == PH_SIDE_GO));
  a_r6_amber_to_main: assert property (@(posedge clk) disable iff (rst)
    (handover && phase == PH_SIDE_AMBER) |=> (phase == PH_MAIN_GO));

  // R4: timer stays inside its phase length
  a_r4_main_bound: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_MAIN_GO) |-> (elapsed <= MAIN_LAST));
  // R7: side green bound
  a_r7_side_bound: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_SIDE_GO) |-> (elapsed <= SIDE_LAST));
  a_r6_amber_bound: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_MAIN_AMBER || phase == PH_SIDE_AMBER) |-> (elapsed <= AMBER_LAST));

endmodule

// File: rtl/tlc_countdown.sv
module tlc_countdown
  import tlc_pkg::*;
#(
  parameter int unsigned MAIN_T  = 45,
  parameter int unsigned SIDE_T  = 25,
  parameter int unsigned AMBER_T = 5,
  parameter int unsigned CW      = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  phase_t        phase,
  input  logic [CW-1:0] elapsed,
  output logic [7:0]    main_bcd,
  output logic [7:0]    side_bcd
);

  int unsigned spent;
  int unsigned own_left;
  int unsigned main_val;
  int unsigned side_val;

  always_comb begin
    spent    = int'(elapsed);
    own_left = 0;
    main_val = 0;
    side_val = 0;
    unique case (phase)
      PH_MAIN_GO: begin
        own_left = time_left(MAIN_T, spent);
        main_val = own_left;
        side_val = own_left + AMBER_T;
      end
      PH_SIDE_GO: begin
        own_left = time_left(SIDE_T, spent);
        side_val = own_left;
        main_val = own_left + AMBER_T;
      end
      default: begin
        own_left = time_left(AMBER_T, spent);
        main_val = own_left;
        side_val = own_left;
      end
    endcase
  end

  assign main_bcd = to_bcd2(main_val);
  assign side_bcd = to_bcd2(side_val);

  // R10: digits are valid BCD and the countdown never reaches zero
  a_r10_main_digits: assert property (@(posedge clk) disable iff (rst)
    (main_bcd[3:0] <= 4'd9) && (main_bcd[7:4] <= 4'd9) && (main_bcd != 8'h00));
  a_r10_side_digits: assert property (@(posedge clk) disable iff (rst)
    (side_bcd[3:0] <= 4'd9) && (side_bcd[7:4] <= 4'd9) && (side_bcd != 8'h00));

endmodule

// File: rtl/tlc_lamp_decode.sv
module tlc_lamp_decode
  import tlc_pkg::*;
(
  input  phase_t     phase,
  output logic [2:0] main_lamp,
  output logic [2:0] side_lamp
);

  always_comb begin
    unique case (phase)
      PH_MAIN_GO:    begin main_lamp = LAMP_GREEN; side_lamp = LAMP_RED;   end
      PH_MAIN_AMBER: begin main_lamp = LAMP_AMBER; side_lamp = LAMP_RED;   end
      PH_SIDE_GO:    begin main_lamp = LAMP_RED;   side_lamp = LAMP_GREEN; end
      default:       begin main_lamp = LAMP_RED;   side_lamp = LAMP_AMBER; end
    endcase
  end

endmodule

// File: rtl/tlc_crossing_ctrl.sv
module tlc_crossing_ctrl
  import tlc_pkg::*;
#(
  parameter int unsigned MAIN_T  = 45,
  parameter int unsigned SIDE_T  = 25,
  parameter int unsigned AMBER_T = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sec_tick,
  input  logic       car_main,
  input  logic       car_side,
  output logic [2:0] main_lamp,
  output logic [2:0] side_lamp,
  output logic [7:0] main_count,
  output logic [7:0] side_count
);

  localparam int unsigned LONGEST = (MAIN_T > SIDE_T) ?
                                    ((MAIN_T > AMBER_T) ? MAIN_T : AMBER_T) :
                                    ((SIDE_T > AMBER_T) ? SIDE_T : AMBER_T);
  localparam int unsigned CW = (LONGEST < 2) ? 1 : $clog2(LONGEST);

  phase_t        phase;
  logic [CW-1:0] elapsed;
  logic          handover;

  tlc_phase_seq #(
    .MAIN_T (MAIN_T),
    .SIDE_T (SIDE_T),
    .AMBER_T(AMBER_T),
    .CW     (CW)
  ) u_seq (
    .clk     (clk),
    .rst     (rst),
    .tick    (sec_tick),
    .car_main(car_main),
    .car_side(car_side),
    .phase   (phase),
    .elapsed (elapsed),
    .handover(handover)
  );

  tlc_countdown #(
    .MAIN_T (MAIN_T),
    .SIDE_T (SIDE_T),
    .AMBER_T(AMBER_T),
    .CW     (CW)
  ) u_count (
    .clk     (clk),
    .rst     (rst),
    .phase   (phase),
    .elapsed (elapsed),
    .main_bcd(main_count),
    .side_bcd(side_count)
  );

  tlc_lamp_decode u_lamps (
    .phase    (phase),
    .main_lamp(main_lamp),
    .side_lamp(side_lamp)
  );

  // R2: one lamp per road
  a_r2_main_onehot: assert property (@(posedge clk) disable iff (rst)
    $countones(main_lamp) == 1);
  a_r2_side_onehot: assert property (@(posedge clk) disable iff (rst)
    $countones(side_lamp) == 1);
  // R2: the road not moving stays red
  a_r2_cross_red: assert property (@(posedge clk) disable iff (rst)
    (main_lamp[0] || main_lamp[1]) |-> side_lamp[2]);
  a_r2_cross_red_side: assert property (@(posedge clk) disable iff (rst)
    (side_lamp[0] || side_lamp[1]) |-> main_lamp[2]);
  // R11: outputs frozen between ticks
  a_r11_outputs_frozen: assert property (@(posedge clk) disable iff (rst)
    !sec_tick |=> ($stable(main_count) && $stable(side_count) && $stable(main_lamp)));
  // R6: every phase change passes through or out of a yellow
  a_r6_handover_path: assert property (@(posedge clk) disable iff (rst)
    handover |=> ($changed(main_lamp) || $changed(side_lamp)));

endmodule

// File: tb/tlc_crossing_ctrl_test.sv
module tlc_crossing_ctrl_test;

  logic       clk = 1'b0;
  logic       rst;
  logic       sec_tick;
  logic       car_main;
  logic       car_side;
  logic [2:0] main_lamp;
  logic [2:0] side_lamp;
  logic [7:0] main_count;
  logic [7:0] side_count;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  tlc_crossing_ctrl uut (
    .clk       (clk),
    .rst       (rst),
    .sec_tick  (sec_tick),
    .car_main  (car_main),
    .car_side  (car_side),
    .main_lamp (main_lamp),
    .side_lamp (side_lamp),
    .main_count(main_count),
    .side_count(side_count)
  );

  // fields: side, main, ticks, main lamp, side lamp, main bcd, side bcd
  localparam int NV = 15;
  localparam logic [29:0] VEC [NV] = '{
    {1'b0, 1'b1, 6'd3,  3'b001, 3'b100, 8'h45, 8'h50},  // R3 idle side
    {1'b1, 1'b1, 6'd10, 3'b001, 3'b100, 8'h35, 8'h40},  // R10 main green countdown
    {1'b1, 1'b1, 6'd34, 3'b001, 3'b100, 8'h01, 8'h06},  // R4 last second of main green
    {1'b1, 1'b1, 6'd1,  3'b010, 3'b100, 8'h05, 8'h05},  // R4 into main yellow
    {1'b0, 1'b0, 6'd4,  3'b010, 3'b100, 8'h01, 8'h01},  // R6 yellow ignores sensors
    {1'b0, 1'b0, 6'd1,  3'b100, 3'b001, 8'h30, 8'h25},  // R6 side green after 5
    {1'b1, 1'b1, 6'd1,  3'b100, 3'b001, 8'h29, 8'h24},  // R10 side green countdown
    {1'b1, 1'b0, 6'd3,  3'b100, 3'b001, 8'h30, 8'h25},  // R9 hold, timer cleared
    {1'b1, 1'b1, 6'd24, 3'b100, 3'b001, 8'h06, 8'h01},  // R7 last second of side green
    {1'b1, 1'b1, 6'd1,  3'b100, 3'b010, 8'h05, 8'h05},  // R7 into side yellow
    {1'b1, 1'b1, 6'd5,  3'b001, 3'b100, 8'h45, 8'h50},  // R6 back to main green
    {1'b1, 1'b0, 6'd1,  3'b010, 3'b100, 8'h05, 8'h05},  // R5 side only cuts green
    {1'b1, 1'b0, 6'd5,  3'b100, 3'b001, 8'h30, 8'h25},  // R6 side green
    {1'b0, 1'b1, 6'd1,  3'b100, 3'b010, 8'h05, 8'h05},  // R8 side leaves
    {1'b0, 1'b0, 6'd5,  3'b001, 3'b100, 8'h45, 8'h50}   // R6 main green again
  };

  task automatic check8(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic check_all(input string tag, input logic [2:0] ml, input logic [2:0] sl,
                           input logic [7:0] mc, input logic [7:0] sc);
    check8({tag, " main lamp"}, {5'd0, main_lamp}, {5'd0, ml});
    check8({tag, " side lamp"}, {5'd0, side_lamp}, {5'd0, sl});
    check8({tag, " main count"}, main_count, mc);
    check8({tag, " side count"}, side_count, sc);
    // R2: one lamp per road and cross red
    check8("R2 lamp rule",
           {7'd0, ($countones(main_lamp) == 1) && ($countones(side_lamp) == 1) &&
                  (main_lamp[2] || side_lamp[2])}, 8'd1);
  endtask

  task automatic give_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      sec_tick = 1'b1;
      @(negedge clk);
      sec_tick = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; sec_tick = 1'b0; car_main = 1'b0; car_side = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_all("R1 reset", 3'b001, 3'b100, 8'h45, 8'h50);

    for (int v = 0; v < NV; v++) begin
      car_side = VEC[v][29];
      car_main = VEC[v][28];
      give_ticks(int'(VEC[v][27:22]));
      check_all($sformatf("vector %0d", v), VEC[v][21:19], VEC[v][18:16],
                VEC[v][15:8], VEC[v][7:0]);
    end

    // R11: no tick, nothing moves (now in main green, both busy)
    car_side = 1'b1; car_main = 1'b1;
    give_ticks(2);
    check_all("R11 before", 3'b001, 3'b100, 8'h43, 8'h48);
    repeat (20) @(negedge clk);
    check_all("R11 idle clocks", 3'b001, 3'b100, 8'h43, 8'h48);

    // R3: side drops, timer clears regardless of main
    car_side = 1'b0;
    give_ticks(1);
    check_all("R3 clear", 3'b001, 3'b100, 8'h45, 8'h50);

    // R1: reset in the middle of side green
    car_side = 1'b1; car_main = 1'b0;
    give_ticks(6);
    check_all("R1 pre", 3'b100, 3'b001, 8'h30, 8'h25);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_all("R1 mid reset", 3'b001, 3'b100, 8'h45, 8'h50);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule